// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address for a memory system with 4 KB pages. It accepts one request at a time. Each request is a virtual address and a flag that marks a write. The walker then reads the tree of page-table entries through a plain word-wide memory port. The top 10 address bits index a directory, and the directory's base frame comes from a base-register input. The directory entry names the frame of a leaf table. The next 10 bits index that leaf table. The leaf entry provides the physical frame, and the low 12 bits of the virtual address pass through unchanged as the page offset.

Both levels are checked for presence. A write is also checked against the leaf's write-permission bit. When a translation succeeds, the walker marks the leaf as referenced, and also as dirty on a write. It writes the leaf back only when one of those bits actually changes. Each request ends with a one-cycle response that carries either the physical address or a fault with its kind.

Entry layout, used by both levels: bits [31:12] hold the frame, bit 0 is present, bit 1 is write-allowed, bit 3 is cache-disable, bit 5 is referenced and bit 6 is dirty. The walker ignores the cache-disable bit and carries it through unchanged.

Top module: `pt_walker`

## Requirements
- R1: The first memory read of a walk is at address {base[19:0], va[31:22], 2'b00}, and every memory address the walker issues is word aligned.
- R2: The second read is at {directory_entry[31:12], va[21:12], 2'b00}.
- R3: A successful translation returns rsp_paddr = {leaf[31:12], va[11:0]} with rsp_fault = 0. For example, va 8196 with leaf frame 6 gives 24580.
- R4: A directory entry with bit 0 clear ends the walk after one read, with rsp_fault = 1 and rsp_kind = 0.
- R5: A leaf entry with bit 0 clear gives rsp_fault = 1 and rsp_kind = 0, with two reads and no write.
- R6: A write to a present leaf whose bit 1 is clear gives rsp_fault = 1 and rsp_kind = 1, and nothing is written back.
- R7: A successful read writes the leaf back with bit 5 set. A successful write writes it back with bits 5 and 6 set. The write-back goes to the leaf's own address, and all other bits are unchanged.
- R8: When the referenced bit (and, for a write, the dirty bit) are already set, no write-back is issued.
- R9: req_ready is low from the cycle after acceptance until the response has been given. rsp_valid lasts exactly one cycle per accepted request, and a req_valid held while busy is ignored.
- R10: After reset, req_ready = 1, mem_req = 0 and rsp_valid = 0.
- R11: While mem_req is high and mem_ack is low, the request and its address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_frame | input | 20 | Frame number of the directory table; must be held during a walk |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 for a write access |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Updated leaf entry |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion of the current access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 1 | Translation failed |
| rsp_kind | output | 1 | Fault kind: 0 not present, 1 write not permitted |

## Verification
The hardest case to reach from the ports is the skipped write-back. A leaf has to reach the state where its status bits are already set, and that happens only after earlier successful walks. The bench therefore walks the same page three times against a shared memory model. The first access is a read, which sets referenced. The second is a write, which sets dirty. The third is another write, and it must produce no memory write. Protection faults are reached with a write to a read-only leaf, followed by a read of the same leaf.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [19:0] base_frame,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  output logic        req_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic        rsp_valid,
  output logic [31:0] rsp_paddr,
  output logic        rsp_fault,
  output logic        rsp_kind
);
  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_REF     = 5;
  localparam int BIT_DIRTY   = 6;

  typedef enum logic [2:0] {S_IDLE, S_DIR, S_LEAF, S_WB, S_RSP} state_t;

  state_t      state;
  logic [31:0] va;
  logic        wr;
  logic [19:0] tbl;
  logic [31:0] pte;
  logic        fault, kind;
  logic [31:0] upd;

  assign upd = mem_rdata | (32'd1 << BIT_REF) | (wr ? (32'd1 << BIT_DIRTY) : 32'd0);

  assign req_ready = (state == S_IDLE);
  assign mem_req   = (state == S_DIR) || (state == S_LEAF) || (state == S_WB);
  assign mem_we    = (state == S_WB);
  assign mem_addr  = (state == S_DIR) ? {base_frame, va[31:22], 2'b00}
                                      : {tbl, va[21:12], 2'b00};
  assign mem_wdata = pte;
  assign rsp_valid = (state == S_RSP);
  assign rsp_fault = fault;
  assign rsp_kind  = kind;
  assign rsp_paddr = fault ? 32'd0 : {pte[31:12], va[11:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      va    <= '0;
      wr    <= 1'b0;
      tbl   <= '0;
      pte   <= '0;
      fault <= 1'b0;
      kind  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va    <= req_vaddr;
          wr    <= req_write;
          fault <= 1'b0;
          kind  <= 1'b0;
          state <= S_DIR;
        end
        S_DIR: if (mem_ack) begin
          if (!mem_rdata[BIT_PRESENT]) begin
            fault <= 1'b1;
            kind  <= 1'b0;
            state <= S_RSP;
          end else begin
            tbl   <= mem_rdata[31:12];
            state <= S_LEAF;
          end
        end
        S_LEAF: if (mem_ack) begin
          if (!mem_rdata[BIT_PRESENT]) begin
            fault <= 1'b1;
            kind  <= 1'b0;
            state <= S_RSP;
          end else if (wr && !mem_rdata[BIT_WRITE]) begin
            fault <= 1'b1;
            kind  <= 1'b1;
            state <= S_RSP;
          end else begin
            pte   <= upd;
            state <= (upd != mem_rdata) ? S_WB : S_RSP;
          end
        end
        S_WB:  if (mem_ack) state <= S_RSP;
        S_RSP: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_vaddr,
  input logic        req_ready,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack,
  input logic        rsp_valid,
  input logic [31:0] rsp_paddr,
  input logic        rsp_fault
);
  logic [11:0] off_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) off_q <= '0;
    else if (req_valid && req_ready) off_q <= req_vaddr[11:0];

  // R1
  aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_paddr[11:0] == off_q);
  // R7
  wb_ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[5]);
  // R9
  one_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R9
  busy_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready && !mem_req);
  // R11
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .req_ready(req_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack), .rsp_valid(rsp_valid),
  .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] base_frame = 20'h00010;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_fault, rsp_kind;

  always #2.5 clk = ~clk;

  pt_walker u_dut (.*);

  logic [31:0] mem [int unsigned];
  int n_rd, n_wr;
  logic [31:0] rd_addr [0:3];
  logic [31:0] wr_addr, wr_data;
  int checks = 0, errors = 0;

  initial forever begin
    @(negedge clk);
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        wr_addr = mem_addr; wr_data = mem_wdata; n_wr++;
      end else begin
        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'd0;
        if (n_rd < 4) rd_addr[n_rd] = mem_addr;
        n_rd++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  logic [31:0] r_pa;
  logic r_f, r_k;
  bit busy_bad;
  int n_rsp;

  task automatic walk(input logic [31:0] va, input bit w, input bit hold);
    int guard = 0;
    n_rd = 0; n_wr = 0; busy_bad = 0; n_rsp = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = w;
    @(negedge clk);
    if (hold) req_vaddr = ~va; else req_valid = 1'b0;
    while (!rsp_valid && guard < 100) begin
      if (req_ready) busy_bad = 1;
      @(negedge clk); guard++;
    end
    if (rsp_valid) n_rsp++;
    r_pa = rsp_paddr; r_f = rsp_fault; r_k = rsp_kind;
    req_valid = 1'b0;
    repeat (4) begin
      @(negedge clk);
      if (rsp_valid) n_rsp++;
    end
  endtask

  task automatic t_reset;
    check(req_ready === 1'b1, "R10 ready", {31'd0, req_ready}, 32'd1);
    check(mem_req === 1'b0 && rsp_valid === 1'b0, "R10 idle outputs", {30'd0, mem_req, rsp_valid}, 32'd0);
  endtask

  task automatic t_read_first;
    walk(32'd8196, 1'b0, 1'b0);
    check(rd_addr[0] == 32'h0001_0000, "R1 directory address", rd_addr[0], 32'h0001_0000);
    check(rd_addr[1] == 32'h0002_0008, "R2 leaf address", rd_addr[1], 32'h0002_0008);
    check(!r_f && r_pa == 32'd24580, "R3 paddr", r_pa, 32'd24580);
    check(n_wr == 1 && wr_addr == 32'h0002_0008 && wr_data == 32'h0000_6023,
          "R7 read sets referenced", wr_data, 32'h0000_6023);
    check(!busy_bad && n_rsp == 1, "R9 busy and single response", n_rsp, 32'd1);
  endtask

  task automatic t_write_dirty;
    walk(32'h0000_2FFC, 1'b1, 1'b0);
    check(!r_f && r_pa == 32'h0000_6FFC, "R3 paddr write", r_pa, 32'h0000_6FFC);
    check(n_wr == 1 && wr_data == 32'h0000_6063, "R7 write sets dirty", wr_data, 32'h0000_6063);
  endtask

  task automatic t_no_wb;
    walk(32'h0000_2010, 1'b1, 1'b0);
    check(n_wr == 0, "R8 no write-back when bits set", n_wr, 32'd0);
    check(!r_f && r_pa == 32'h0000_6010, "R3 paddr repeat", r_pa, 32'h0000_6010);
  endtask

  task automatic t_dir_absent;
    walk(32'h0140_0123, 1'b0, 1'b0);
    check(r_f && !r_k, "R4 directory fault kind", {r_f, r_k}, 32'd2);
    check(n_rd == 1 && n_wr == 0, "R4 single read", n_rd, 32'd1);
  endtask

  task automatic t_leaf_absent;
    walk(32'h0000_7000, 1'b1, 1'b0);
    check(r_f && !r_k && r_pa == 32'd0, "R5 leaf fault", {r_f, r_k}, 32'd2);
    check(n_rd == 2 && n_wr == 0, "R5 two reads no write", n_rd, 32'd2);
  endtask

  task automatic t_protect;
    walk(32'h0040_3ABC, 1'b1, 1'b0);
    check(r_f && r_k, "R6 protection fault kind", {r_f, r_k}, 32'd3);
    check(n_wr == 0 && mem[32'h0003_000C] == 32'h00AB_C001, "R6 entry untouched",
          mem[32'h0003_000C], 32'h00AB_C001);
    walk(32'h0040_3ABC, 1'b0, 1'b0);
    check(!r_f && r_pa == 32'h00AB_CABC, "R3 read of read-only page", r_pa, 32'h00AB_CABC);
    check(n_wr == 1 && wr_data == 32'h00AB_C021, "R7 read-only referenced", wr_data, 32'h00AB_C021);
  endtask

  task automatic t_hold_busy;
    walk(32'h0000_2444, 1'b0, 1'b1);
    check(!busy_bad && n_rsp == 1, "R9 held request ignored", n_rsp, 32'd1);
    check(n_rd == 2 && n_wr == 0, "R9 no extra walk", n_rd, 32'd2);
    check(r_pa == 32'h0000_6444, "R9 paddr of first request", r_pa, 32'h0000_6444);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    mem[32'h0001_0000] = 32'h0002_0001;
    mem[32'h0002_0008] = 32'h0000_6003;
    mem[32'h0001_0004] = 32'h0003_0001;
    mem[32'h0003_000C] = 32'h00AB_C001;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_read_first;
    t_write_dirty;
    t_no_wb;
    t_dir_absent;
    t_leaf_absent;
    t_protect;
    t_hold_busy;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule